// File: doc/BRIEF.md
# Dual Control Word Register

This block is the control-side register of a serial display driver. A host sends bytes over a shared serial bus made of a serial clock, an active-low chip enable, a register-select line and a data line. When the select line is high at the moment chip enable falls, the block treats the transfer as a control write. Each rising serial-clock edge shifts one bit into an 8-bit control shift register, most significant bit first. When chip enable returns high and the serial clock is low, the top bit of that register picks one of two 7-bit control words. The lower seven bits are copied into the chosen word, and the other word keeps its value.

Word 0 gives a 4-bit PWM brightness code, a 2-bit peak-current code and an awake bit, where 0 means sleep. Word 1 gives a simultaneous-mode bit and an external-oscillator divide-by-8 bit. The block also drives the data-out pin used for chaining. During control writes that pin carries the top shift-register bit (serial mode) or follows data-in directly (simultaneous mode). During dot writes it carries the tail bit of the external dot shift register.

All bus inputs are sampled on the fabric clock `clk`. Each level must be held for at least two `clk` cycles.

Top module: `ctrl_word_reg`

## Requirements
- R1: While chip enable (`ce_n`) is low and the latched target is control, each rising edge of `sclk` shifts `din` into bit 0 of the 8-bit control shift register, and every other bit moves one place toward bit 7. The first bit sent therefore ends in bit 7.
- R2: The target is taken from `rs` only when `ce_n` falls: 1 selects control, 0 selects dot. Changing `rs` while `ce_n` stays low has no effect on the transfer.
- R3: After at least one control shift, the first cycle with `ce_n` high and `sclk` low commits the transfer. Bits 6..0 of the shift register go into word 0 if bit 7 is 0, or into word 1 if bit 7 is 1. The word that is not selected keeps its value, and the word outputs do not change at any other time.
- R4: Word 0 fields: `pwm_code` is bits 3..0, `peak_code` is bits 5..4, and `awake` is bit 6 (0 = sleep, 1 = running).
- R5: Word 1 fields: `sim_mode` is bit 0 and `osc_div8` is bit 1. Bits 6..2 are stored but drive no output.
- R6: With the target at control and `sim_mode` = 0, `dout` equals bit 7 of the control shift register.
- R7: With the target at control and `sim_mode` = 1, `dout` follows `din` with no register in between. Two devices chained `dout` to `din` then both load the same byte in 8 serial clocks.
- R8: With the target at dot, `dout` equals `dot_tail`, whatever the value of `sim_mode`.
- R9: Rising `sclk` edges while `ce_n` is high shift nothing and commit nothing.
- R10: Synchronous active-high `rst` clears both words and the control shift register, which means sleep, serial mode and divide-by-1. It also sets the target to dot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all bus inputs are sampled on it |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial bus clock |
| ce_n | input | 1 | Bus chip enable, active low |
| rs | input | 1 | Target select, captured when `ce_n` falls (1 = control) |
| din | input | 1 | Serial data in |
| dot_tail | input | 1 | Last bit of the external dot shift register |
| dout | output | 1 | Serial data out for chaining |
| pwm_code | output | 4 | PWM brightness code from word 0 |
| peak_code | output | 2 | Peak-current code from word 0 |
| awake | output | 1 | 1 = running, 0 = sleep (word 0) |
| sim_mode | output | 1 | Simultaneous data-out mode (word 1) |
| osc_div8 | output | 1 | External oscillator divide-by-8 (word 1) |

## Verification
Two functions can act on `dout` in the same cycle. A commit to word 1 can switch between serial and simultaneous mode, and at that same edge the source of `dout` changes from the shift register's top bit to `din`. The bench provokes this by committing a word-1 byte while holding `din` opposite to bit 7 of the shift register, first to enter simultaneous mode and then to leave it. It then samples `dout` after the commit and compares it with the value the new mode predicts. Two instances are chained, so the 8-clock broadcast and the 16-clock serial load are both judged on the field outputs of each instance.

// File: rtl/ctrl_word_pkg.sv
package ctrl_word_pkg;
  typedef enum logic {
    TGT_DOT  = 1'b0,
    TGT_CTRL = 1'b1
  } tgt_e;
endpackage

// File: rtl/ctrl_word_front.sv
module ctrl_word_front
  import ctrl_word_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic ce_n,
  input  logic rs,
  output tgt_e tgt,
  output logic shift_en,
  output logic commit
);
  logic sclk_q;
  logic ce_q;
  logic pend;
  logic sclk_rise;
  logic ce_fall;

  assign sclk_rise = sclk & ~sclk_q;
  assign ce_fall   = ce_q & ~ce_n;
  assign shift_en  = sclk_rise & ~ce_n & (tgt == TGT_CTRL);
  assign commit    = pend & ce_n & ~sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      ce_q   <= 1'b1;
      tgt    <= TGT_DOT;
      pend   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      ce_q   <= ce_n;
      if (ce_fall) tgt <= tgt_e'(rs);
      if (shift_en)    pend <= 1'b1;
      else if (commit) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ctrl_word_shreg.sv
module ctrl_word_shreg #(
  parameter int SR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            din,
  output logic [SR_W-1:0] sreg
);
  always_ff @(posedge clk) begin
    if (rst)           sreg <= '0;
    else if (shift_en) sreg <= {sreg[SR_W-2:0], din};
  end
endmodule

// File: rtl/ctrl_word_bank.sv
module ctrl_word_bank #(
  parameter int CW_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            commit,
  input  logic            sel,
  input  logic [CW_W-1:0] payload,
  output logic [CW_W-1:0] word0,
  output logic [CW_W-1:0] word1
);
  localparam int N_WORDS = 2;
  logic [CW_W-1:0] words [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    localparam logic IDX = 1'(g);
    always_ff @(posedge clk) begin
      if (rst)                        words[g] <= '0;
      else if (commit && sel == IDX)  words[g] <= payload;
    end
  end

  assign word0 = words[0];
  assign word1 = words[1];
endmodule

// File: rtl/ctrl_word_reg.sv
module ctrl_word_reg
  import ctrl_word_pkg::*;
#(
  parameter int PWM_W  = 4,
  parameter int PEAK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              ce_n,
  input  logic              rs,
  input  logic              din,
  input  logic              dot_tail,
  output logic              dout,
  output logic [PWM_W-1:0]  pwm_code,
  output logic [PEAK_W-1:0] peak_code,
  output logic              awake,
  output logic              sim_mode,
  output logic              osc_div8
);
  localparam int CW_W     = PWM_W + PEAK_W + 1;
  localparam int SR_W     = CW_W + 1;
  localparam int PEAK_LSB = PWM_W;
  localparam int AWAKE_B  = PWM_W + PEAK_W;

  tgt_e            tgt;
  logic            shift_en;
  logic            commit;
  logic [SR_W-1:0] sreg;
  logic [CW_W-1:0] word0;
  logic [CW_W-1:0] word1;

  ctrl_word_front u_front (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .ce_n     (ce_n),
    .rs       (rs),
    .tgt      (tgt),
    .shift_en (shift_en),
    .commit   (commit)
  );

  ctrl_word_shreg #(.SR_W(SR_W)) u_shreg (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .din      (din),
    .sreg     (sreg)
  );

  ctrl_word_bank #(.CW_W(CW_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .commit  (commit),
    .sel     (sreg[SR_W-1]),
    .payload (sreg[CW_W-1:0]),
    .word0   (word0),
    .word1   (word1)
  );

  assign pwm_code  = word0[PWM_W-1:0];
  assign peak_code = word0[PEAK_LSB +: PEAK_W];
  assign awake     = word0[AWAKE_B];
  assign sim_mode  = word1[0];
  assign osc_div8  = word1[1];

  always_comb begin
    if (tgt == TGT_CTRL) dout = sim_mode ? din : sreg[SR_W-1];
    else                 dout = dot_tail;
  end
endmodule

// File: rtl/ctrl_word_reg_chk.sv
module ctrl_word_reg_chk #(
  parameter int SR_W = 8,
  parameter int CW_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            din,
  input logic            shift_en,
  input logic            commit,
  input logic [SR_W-1:0] sreg,
  input logic [CW_W-1:0] word0,
  input logic [CW_W-1:0] word1
);
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> sreg[0] == $past(din)); // R1

  AST_KEEP_WORD0: assert property (@(posedge clk) disable iff (rst)
    (commit && sreg[SR_W-1]) |=> $stable(word0)); // R3

  AST_KEEP_WORD1: assert property (@(posedge clk) disable iff (rst)
    (commit && !sreg[SR_W-1]) |=> $stable(word1)); // R3

  AST_WORDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(word0) && $stable(word1))); // R3

  AST_SREG_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sreg)); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (word0 == '0 && word1 == '0 && sreg == '0)); // R10
endmodule

bind ctrl_word_reg ctrl_word_reg_chk #(.SR_W(SR_W), .CW_W(CW_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .din      (din),
  .shift_en (shift_en),
  .commit   (commit),
  .sreg     (sreg),
  .word0    (word0),
  .word1    (word1)
);

// File: tb/ctrl_word_reg_tb.sv
module ctrl_word_reg_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, ce_n = 1'b1, rs = 1'b0, din = 1'b0;
  logic dot_tail = 1'b1, dot_tail_b = 1'b0;
  logic dout_a, dout_b;
  logic [3:0] pwm_a, pwm_b;
  logic [1:0] peak_a, peak_b;
  logic awake_a, awake_b, sim_a, sim_b, div8_a, div8_b;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctrl_word_reg u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .ce_n(ce_n), .rs(rs), .din(din),
    .dot_tail(dot_tail), .dout(dout_a), .pwm_code(pwm_a), .peak_code(peak_a),
    .awake(awake_a), .sim_mode(sim_a), .osc_div8(div8_a));

  ctrl_word_reg u_dut_b (
    .clk(clk), .rst(rst), .sclk(sclk), .ce_n(ce_n), .rs(rs), .din(dout_a),
    .dot_tail(dot_tail_b), .dout(dout_b), .pwm_code(pwm_b), .peak_code(peak_b),
    .awake(awake_b), .sim_mode(sim_b), .osc_div8(div8_b));

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic ser_write(input logic [15:0] val, input int nbits,
                           input logic rs_fall, input logic rs_late);
    rs = rs_fall; wait_clk(2);
    ce_n = 1'b0;  wait_clk(2);
    rs = rs_late;
    for (int i = nbits - 1; i >= 0; i--) begin
      din = val[i]; wait_clk(2);
      sclk = 1'b1;  wait_clk(2);
      if (i > 0) sclk = 1'b0;
    end
    ce_n = 1'b1; wait_clk(2);
    sclk = 1'b0; wait_clk(3);
  endtask

  task automatic check_w0(input string tag, input logic [6:0] v);
    chk({tag, " pwm"},   16'(pwm_a),   16'(v[3:0]));
    chk({tag, " peak"},  16'(peak_a),  16'(v[5:4]));
    chk({tag, " awake"}, 16'(awake_a), 16'(v[6]));
  endtask

  initial begin
    logic [15:0] cat;
    wait_clk(4);
    rst = 1'b0; wait_clk(2);
    // R10: reset state
    chk("R10 reset pwm", 16'(pwm_a), 0);
    chk("R10 reset peak", 16'(peak_a), 0);
    chk("R10 reset awake(sleep)", 16'(awake_a), 0);
    chk("R10 reset sim", 16'(sim_a), 0);
    chk("R10 reset div8", 16'(div8_a), 0);
    chk("R8 reset dout=dot_tail", 16'(dout_a), 1);

    // R4 exhaustive word 0 sweep; R3 word 1 untouched; R6 dout is sreg bit7 (0)
    for (int v = 0; v < 128; v++) begin
      ser_write(16'(v), 8, 1'b1, 1'b1);
      check_w0("R4 sweep", 7'(v));
      chk("R3 sweep w1 sim kept", 16'(sim_a), 0);
      chk("R3 sweep w1 div8 kept", 16'(div8_a), 0);
      chk("R6 sweep dout", 16'(dout_a), 0);
    end

    // R5 word 1 fields; R3 word 0 kept (last sweep value 0x7F)
    for (int m = 0; m < 4; m++) begin
      ser_write(16'(8'h80 | m), 8, 1'b1, 1'b1);
      chk("R5 sim", 16'(sim_a), 16'(m & 1));
      chk("R5 div8", 16'(div8_a), 16'((m >> 1) & 1));
      check_w0("R3 w0 kept", 7'h7F);
    end
    ser_write(16'h0080, 8, 1'b1, 1'b1);
    ser_write(16'h003C, 8, 1'b1, 1'b1);
    check_w0("R4 3C", 7'h3C);

    // R1/R6 serial dout during a partial write: prev 0x3C then 0x80
    cat = 16'h3C80;
    rs = 1'b1; wait_clk(2); ce_n = 1'b0; wait_clk(2);
    for (int k = 1; k <= 8; k++) begin
      din = cat[8 - k]; wait_clk(2);
      sclk = 1'b1; wait_clk(2);
      chk("R1 shift order dout", 16'(dout_a), 16'(cat[15 - k]));
      if (k < 8) sclk = 1'b0;
    end
    ce_n = 1'b1; wait_clk(2); sclk = 1'b0; wait_clk(3);
    chk("R3 commit 80 sim", 16'(sim_a), 0);
    check_w0("R3 w0 kept after 80", 7'h3C);
    chk("R6 dout after commit", 16'(dout_a), 1);
    // R9: sclk pulses with ce_n high are ignored
    for (int p = 0; p < 3; p++) begin
      din = 1'b0; wait_clk(2); sclk = 1'b1; wait_clk(2); sclk = 1'b0; wait_clk(2);
    end
    chk("R9 dout unchanged", 16'(dout_a), 1);
    check_w0("R9 w0 unchanged", 7'h3C);
    chk("R9 sim unchanged", 16'(sim_a), 0);

    // R2: rs only counts at ce_n fall
    ser_write(16'h000F, 8, 1'b1, 1'b0);
    check_w0("R2 ctrl despite rs drop", 7'h0F);
    ser_write(16'h0081, 8, 1'b0, 1'b1);
    chk("R2 dot write ignores rs rise sim", 16'(sim_a), 0);
    check_w0("R2 dot write w0", 7'h0F);

    // Same-cycle interplay: enter sim mode, din held opposite to sreg bit7
    ser_write(16'h0081, 8, 1'b1, 1'b1);
    chk("R5 sim set", 16'(sim_a), 1);
    din = 1'b0; wait_clk(1);
    chk("R7 dout=din after sim commit", 16'(dout_a), 0);
    din = 1'b1; wait_clk(1);
    chk("R7 dout follows din", 16'(dout_a), 1);

    // R8: dot target ignores sim mode
    rs = 1'b0; wait_clk(2); ce_n = 1'b0; wait_clk(2);
    din = 1'b1; dot_tail = 1'b0; wait_clk(1);
    chk("R8 dot dout 0", 16'(dout_a), 0);
    din = 1'b0; dot_tail = 1'b1; wait_clk(1);
    chk("R8 dot dout 1", 16'(dout_a), 1);
    ce_n = 1'b1; wait_clk(3);
    chk("R8 sim kept after dot", 16'(sim_a), 1);

    // R7: broadcast; first make both sim, then an 8-clock word 0 load
    ser_write(16'h0081, 8, 1'b1, 1'b1);
    chk("R7 b sim", 16'(sim_b), 1);
    ser_write(16'h005A, 8, 1'b1, 1'b1);
    check_w0("R7 a bcast", 7'h5A);
    chk("R7 b pwm", 16'(pwm_b), 16'hA);
    chk("R7 b peak", 16'(peak_b), 1);
    chk("R7 b awake", 16'(awake_b), 1);
    // leave sim mode on both; din held 0 while sreg bit7 = 1
    ser_write(16'h0080, 8, 1'b1, 1'b1);
    din = 1'b0; wait_clk(1);
    chk("R6 dout back to sreg", 16'(dout_a), 1);
    chk("R5 b sim cleared", 16'(sim_b), 0);

    // R1: serial chain, 16 clocks: first byte lands in b
    ser_write(16'h2B47, 16, 1'b1, 1'b1);
    check_w0("R1 chain a", 7'h47);
    chk("R1 chain b pwm", 16'(pwm_b), 16'hB);
    chk("R1 chain b peak", 16'(peak_b), 2);
    chk("R1 chain b awake", 16'(awake_b), 0);

    // R10: mid-run reset clears words and shift register
    ser_write(16'h0083, 8, 1'b1, 1'b1);
    chk("R5 div8 before reset", 16'(div8_a), 1);
    rst = 1'b1; wait_clk(2); rst = 1'b0; wait_clk(2);
    chk("R10 pwm cleared", 16'(pwm_a), 0);
    chk("R10 div8 cleared", 16'(div8_a), 0);
    chk("R10 sim cleared", 16'(sim_a), 0);
    rs = 1'b1; wait_clk(2); ce_n = 1'b0; wait_clk(3);
    chk("R10 sreg cleared via dout", 16'(dout_a), 0);
    ce_n = 1'b1; wait_clk(3);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule